// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block keeps a four-bank SDRAM refreshed while normal traffic runs. A divider counts system clocks. Each time a programmable interval elapses, one refresh becomes owed. The block issues an auto refresh command on its own command outputs once the command sequencer reports that every bank is precharged and no burst is running. After each refresh it blocks new row activations until the row cycle time has passed.

Refreshes that cannot be issued at once are kept in a small saturating debt counter. While any refresh is owed, the block refuses activation requests. This lets the sequencer close its banks without any burst being cut short. When the debt reaches its ceiling, the block raises a forced precharge-all request.

A level request puts the memory into self-refresh. The block sends the refresh command with clock enable dropping low in the same cycle, and keeps clock enable low while the request stays high. When the request drops, clock enable returns high, and commands stay blocked for one row cycle time.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With the banks always idle, one auto refresh command is issued every INTERVAL clocks. After reset the first one appears on the output INTERVAL+1 cycles after reset is released.
- R2: `cmd_o` carries {chip select, row strobe, column strobe, write enable}, all active low. Refresh is 4'b0001 and every other cycle is NOP (4'b0111). An auto refresh has `cke_o` high in its own cycle and in the cycle before it. After reset the outputs are NOP, `cke_o`=1, and both request outputs are 0.
- R3: A refresh command is only issued if `all_idle_i` was high and `burst_busy_i` was low at the clock edge that launched it.
- R4: After an auto refresh command, `act_grant_o` stays low for TRC_CLK cycles, counting the command's own cycle, even if nothing is owed.
- R5: `act_grant_o` equals `act_req_i` only when no refresh is owed, no hold-off is running and `sr_req_i` is low. Otherwise it is 0. `ref_want_o` is high whenever a refresh is owed.
- R6: Refreshes that could not be issued accumulate. Once the banks are idle they are issued back to back, TRC_CLK+1 cycles apart.
- R7: The debt saturates at 2**DEBT_W-1. `pall_req_o` is high exactly while the debt is at that ceiling. A saturated debt is paid back with exactly that many refreshes.
- R8: With `sr_req_i` high and the banks idle, the block sends the refresh command with `cke_o` going low in the same cycle. While `sr_req_i` stays high, `cke_o` stays low, only NOPs are sent and no refresh is owed.
- R9: The cycle after `sr_req_i` is seen low in self-refresh, `cke_o` rises. Activations stay blocked for TRC_CLK cycles from that cycle. The interval divider restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| all_idle_i | input | 1 | Sequencer reports every bank precharged |
| burst_busy_i | input | 1 | A read or write burst is in progress |
| act_req_i | input | 1 | Sequencer wants to open a row |
| sr_req_i | input | 1 | Level request to stay in self-refresh |
| act_grant_o | output | 1 | Row activation permitted this cycle |
| ref_want_o | output | 1 | At least one refresh is owed; close banks |
| pall_req_o | output | 1 | Debt at ceiling; precharge all banks now |
| cke_o | output | 1 | Clock enable to the SDRAM |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} command |

## Verification
The hardest state to reach from the ports is a saturated debt counter being paid back. The bench holds `all_idle_i` low across more intervals than the counter can record. It then releases the banks well away from the next interval tick, so the number of refreshes in the drain window must match the ceiling exactly, not the number of ticks. Self-refresh exit gets the same kind of treatment. The bench keeps an activation request asserted over the wake-up and counts the blocked cycles from the rise of clock enable.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   // {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] sd_cmd_t;
   localparam sd_cmd_t CMD_NOP = 4'b0111;
   localparam sd_cmd_t CMD_REF = 4'b0001;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HOLD = 2'd1,
      ST_SELF = 2'd2,
      ST_WAKE = 2'd3
   } rfs_state_e;
endpackage

// File: rtl/rfs_interval_tick.sv
module rfs_interval_tick #(
   parameter int INTERVAL = 1562
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int  CW     = (INTERVAL < 2) ? 1 : $clog2(INTERVAL);
   localparam bit  IS_POW2 = ((INTERVAL & (INTERVAL - 1)) == 0);

   logic [CW-1:0] cnt_q;

   generate
      if (IS_POW2) begin : g_wrap
         // counter wraps on its own width
         always_ff @(posedge clk) begin
            if (!rst_n || !run_i) cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = run_i && (&cnt_q);
      end else begin : g_cmp
         logic last;
         assign last = (cnt_q == CW'(INTERVAL - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || !run_i) cnt_q <= '0;
            else if (last)        cnt_q <= '0;
            else                  cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = run_i && last;
      end
   endgenerate
endmodule

// File: rtl/rfs_debt_ctr.sv
module rfs_debt_ctr #(
   parameter int DEBT_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc_i,
   input  logic dec_i,
   input  logic clr_i,
   output logic owed_o,
   output logic full_o
);
   localparam logic [DEBT_W-1:0] DEBT_MAX = '1;

   logic [DEBT_W-1:0] debt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         debt_q <= '0;
      end else if (inc_i && !dec_i) begin
         if (debt_q != DEBT_MAX) debt_q <= debt_q + 1'b1;
      end else if (dec_i && !inc_i) begin
         if (debt_q != '0) debt_q <= debt_q - 1'b1;
      end
   end

   assign owed_o = (debt_q != '0);
   assign full_o = (debt_q == DEBT_MAX);
endmodule

// File: rtl/rfs_hold_timer.sv
module rfs_hold_timer #(
   parameter int TRC_CLK = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);
   localparam int CW = $clog2(TRC_CLK + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= CW'(TRC_CLK - 1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
   import rfs_pkg::*;
#(
   parameter int INTERVAL = 1562,
   parameter int TRC_CLK  = 7,
   parameter int DEBT_W   = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       all_idle_i,
   input  logic       burst_busy_i,
   input  logic       act_req_i,
   input  logic       sr_req_i,
   output logic       act_grant_o,
   output logic       ref_want_o,
   output logic       pall_req_o,
   output logic       cke_o,
   output logic [3:0] cmd_o
);
   generate
      if (INTERVAL < 2)  begin : g_bad_itv  $error("INTERVAL must be at least 2");  end
      if (TRC_CLK < 1)   begin : g_bad_trc  $error("TRC_CLK must be at least 1");   end
      if (DEBT_W < 2)    begin : g_bad_debt $error("DEBT_W must be at least 2");    end
      if (TRC_CLK >= INTERVAL) begin : g_bad_mix $error("TRC_CLK must be below INTERVAL"); end
   endgenerate

   rfs_state_e st_q;
   sd_cmd_t    cmd_q;
   logic       cke_q;

   logic tick, owed, full, hold_done;
   logic in_run, go_ok, enter_self, fire_ref, leave_self, load_hold;

   assign in_run     = (st_q == ST_RUN);
   assign go_ok      = in_run && all_idle_i && !burst_busy_i;
   assign enter_self = go_ok && sr_req_i;
   assign fire_ref   = go_ok && !sr_req_i && owed;
   assign leave_self = (st_q == ST_SELF) && !sr_req_i;
   assign load_hold  = fire_ref || leave_self;

   rfs_interval_tick #(.INTERVAL(INTERVAL)) itv_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (st_q != ST_SELF),
      .tick_o (tick)
   );

   rfs_debt_ctr #(.DEBT_W(DEBT_W)) debt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (tick),
      .dec_i  (fire_ref),
      .clr_i  (enter_self || (st_q == ST_SELF)),
      .owed_o (owed),
      .full_o (full)
   );

   rfs_hold_timer #(.TRC_CLK(TRC_CLK)) hold_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_hold),
      .done_o (hold_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_RUN;
         cmd_q <= CMD_NOP;
         cke_q <= 1'b1;
      end else begin
         cmd_q <= CMD_NOP;
         unique case (st_q)
            ST_RUN: begin
               if (enter_self) begin
                  st_q  <= ST_SELF;
                  cmd_q <= CMD_REF;
                  cke_q <= 1'b0;
               end else if (fire_ref) begin
                  st_q  <= ST_HOLD;
                  cmd_q <= CMD_REF;
               end
            end
            ST_HOLD, ST_WAKE: begin
               if (hold_done) st_q <= ST_RUN;
            end
            ST_SELF: begin
               if (leave_self) begin
                  st_q  <= ST_WAKE;
                  cke_q <= 1'b1;
               end
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

   assign act_grant_o = act_req_i && in_run && !owed && !sr_req_i;
   assign ref_want_o  = owed;
   assign pall_req_o  = full;
   assign cke_o       = cke_q;
   assign cmd_o       = cmd_q;
endmodule

// File: rtl/rfs_sched_chk.sv
module rfs_sched_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       all_idle_i,
   input logic       burst_busy_i,
   input logic       act_req_i,
   input logic       act_grant_o,
   input logic       ref_want_o,
   input logic       pall_req_o,
   input logic       cke_o,
   input logic [3:0] cmd_o
);
   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_REF = 4'b0001;

   // R2
   cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_NOP) || (cmd_o == C_REF));

   // R2
   auto_ref_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_REF && cke_o) |-> $past(cke_o));

   // R3
   ref_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_REF) |-> ($past(all_idle_i) && !$past(burst_busy_i)));

   // R4
   no_act_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == C_REF) |=> !act_grant_o);

   // R5
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_grant_o |-> (act_req_i && !ref_want_o));

   // R7
   pall_implies_want_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pall_req_o |-> ref_want_o);

   // R8
   self_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_o && !$fell(cke_o)) |-> (cmd_o == C_NOP && !ref_want_o));

   // R8
   self_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |-> (cmd_o == C_REF));

   // R9
   wake_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke_o) |-> (!act_grant_o && cmd_o == C_NOP));
endmodule

bind sdram_refresh_sched rfs_sched_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .all_idle_i   (all_idle_i),
   .burst_busy_i (burst_busy_i),
   .act_req_i    (act_req_i),
   .act_grant_o  (act_grant_o),
   .ref_want_o   (ref_want_o),
   .pall_req_o   (pall_req_o),
   .cke_o        (cke_o),
   .cmd_o        (cmd_o)
);

// File: tb/sdram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb_top;
   localparam int ITV = 100;
   localparam int TRC = 7;
   localparam int DW  = 3;
   localparam logic [3:0] NOP = 4'b0111;
   localparam logic [3:0] REF = 4'b0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idle = 1'b0, busy = 1'b0, areq = 1'b0, sreq = 1'b0;
   logic grant, want, pall, cke;
   logic [3:0] cmd;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   sdram_refresh_sched #(.INTERVAL(ITV), .TRC_CLK(TRC), .DEBT_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .all_idle_i(idle), .burst_busy_i(busy),
      .act_req_i(areq), .sr_req_i(sreq), .act_grant_o(grant),
      .ref_want_o(want), .pall_req_o(pall), .cke_o(cke), .cmd_o(cmd));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) step();
   endtask

   task automatic do_reset();
      rst_n = 1'b0; idle = 1'b0; busy = 1'b0; areq = 1'b0; sreq = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cmd == NOP, "R2 reset cmd", cmd, NOP);
      chk(cke == 1'b1, "R2 reset cke", cke, 1);
      chk(want == 1'b0 && pall == 1'b0, "R2 reset requests", {want, pall}, 0);
   endtask

   task automatic t_interval();
      int first;
      do_reset();
      idle = 1'b1; areq = 1'b1;
      while (cmd != REF && cyc < 300) step();
      first = cyc;
      chk(first == ITV + 1, "R1 first refresh cycle", first, ITV + 1);
      chk(cmd == REF && cke, "R2 auto refresh code with cke", {cke, cmd}, {1'b1, REF});
      chk(grant == 1'b0, "R4 grant at refresh cycle", grant, 0);
      for (int k = 1; k < TRC; k++) begin
         step();
         chk(grant == 1'b0, "R4 grant during hold-off", grant, 0);
      end
      step();
      chk(grant == 1'b1, "R4 grant after hold-off", grant, 1);
      step();
      while (cmd != REF && cyc < first + 300) step();
      chk(cyc - first == ITV, "R1 refresh spacing", cyc - first, ITV);
   endtask

   task automatic t_postpone();
      int n = 0, t0 = 0, t1 = 0, refs = 0;
      do_reset();
      areq = 1'b1;
      wait_to(50);
      chk(grant == 1'b1, "R5 grant with no debt", grant, 1);
      wait_to(150);
      chk(grant == 1'b0, "R5 grant blocked by debt", grant, 0);
      chk(want == 1'b1, "R5 want while owed", want, 1);
      while (cyc < 350) begin
         step();
         if (cmd == REF) refs++;
      end
      chk(refs == 0, "R3 no refresh while banks open", refs, 0);
      idle = 1'b1;
      while (cyc < 399) begin
         step();
         if (cmd == REF) begin
            if (n == 0) t0 = cyc;
            if (n == 1) t1 = cyc;
            n++;
         end
      end
      chk(n == 3, "R6 postponed refresh count", n, 3);
      chk(t0 == 351, "R6 first postponed refresh", t0, 351);
      chk(t1 - t0 == TRC + 1, "R6 back-to-back spacing", t1 - t0, TRC + 1);
      chk(grant == 1'b1 && want == 1'b0, "R5 grant after debt paid", {grant, want}, 2);
   endtask

   task automatic t_saturate();
      int n = 0;
      do_reset();
      wait_to(650);
      chk(pall == 1'b0, "R7 no force below ceiling", pall, 0);
      wait_to(750);
      chk(pall == 1'b1, "R7 force at ceiling", pall, 1);
      wait_to(920);
      idle = 1'b1;
      while (cyc < 990) begin
         step();
         if (cmd == REF) n++;
      end
      chk(n == (1 << DW) - 1, "R7 saturated debt drain count", n, (1 << DW) - 1);
      chk(want == 1'b0 && pall == 1'b0, "R7 debt cleared", {want, pall}, 0);
   endtask

   task automatic t_burst();
      int n = 0;
      do_reset();
      idle = 1'b1; busy = 1'b1;
      while (cyc < 250) begin
         step();
         if (cmd == REF) n++;
      end
      chk(n == 0, "R3 no refresh during burst", n, 0);
      chk(want == 1'b1, "R3 refresh owed during burst", want, 1);
      busy = 1'b0;
      step();
      chk(cmd == REF, "R3 refresh after burst ends", cmd, REF);
   endtask

   task automatic t_self();
      int n = 0, hi = 0;
      do_reset();
      idle = 1'b1; areq = 1'b1;
      wait_to(50);
      sreq = 1'b1;
      step();
      chk(cmd == REF, "R8 entry command", cmd, REF);
      chk(cke == 1'b0, "R8 cke low at entry", cke, 0);
      chk(grant == 1'b0, "R8 no grant in self-refresh", grant, 0);
      while (cyc < 360) begin
         step();
         if (cmd != NOP) n++;
         if (cke) hi++;
      end
      chk(n == 0, "R8 only NOP while in self-refresh", n, 0);
      chk(hi == 0, "R8 cke held low", hi, 0);
      chk(want == 1'b0, "R8 nothing owed in self-refresh", want, 0);
      sreq = 1'b0;
      step();
      chk(cke == 1'b1, "R9 cke rises on exit", cke, 1);
      chk(cmd == NOP, "R9 no command on exit cycle", cmd, NOP);
      for (int k = 0; k < TRC; k++) begin
         if (k > 0) step();
         chk(grant == 1'b0, "R9 grant blocked after exit", grant, 0);
      end
      step();
      chk(grant == 1'b1, "R9 grant after wake hold-off", grant, 1);
      n = 0;
      while (cyc < 450) begin
         step();
         if (cmd == REF) n++;
      end
      chk(n == 0, "R9 divider restarted", n, 0);
   endtask

   initial begin
      t_reset();
      t_interval();
      t_postpone();
      t_saturate();
      t_burst();
      t_self();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired at cycle %0d: actual=%0d expected=%0d", cyc, 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule